// File: doc/BRIEF.md
# Timer Match Output Unit

A 16-bit free-running up-counter with four compare channels. Each channel holds a 16-bit compare value and a 2-bit action code. When the counter first equals a channel's compare value, that channel's output bit is left alone, forced low, forced high or inverted, as its action code selects. The four output bits are driven straight to the block's `matchOut` port. They can also be read and written through one combined control/status word.

Software reaches the compare values, the control/status word and the live counter through a small synchronous register port. The port has one write strobe and one read strobe. Read data is registered, so it appears one cycle after the strobe. The counter advances once per cycle while `cntEn` is high. `cntClr` holds it at zero. No prescaler, capture input or interrupt is present. The output bits are always driven, whether or not anything downstream uses them.

Top module: `tmr_match_top`

## Requirements
- R1: While `cntClr` is low and `cntEn` is high, the counter rises by one per clock and wraps from 0xFFFF to 0x0000. While `cntEn` is low, the counter holds its value.
- R2: While `cntClr` is high, the counter is zero after the next edge, whatever `cntEn` is.
- R3: A channel fires once, in the first cycle in which the counter equals its compare value. If the counter stays on that value, the channel does not fire again.
- R4: The action of a channel that fires is seen on `matchOut` after the clock edge that ends the cycle in which the counter equalled the compare value, and not earlier.
- R5: Action code 00 leaves the output bit unchanged when the channel fires.
- R6: Action code 01 drives the output bit to 0 when the channel fires.
- R7: Action code 10 drives the output bit to 1 when the channel fires.
- R8: Action code 11 inverts the output bit when the channel fires. The bit inverts again each time the counter wraps around and reaches the same value.
- R9: In the control/status word, bits 3:0 are the levels of outputs 0 to 3. The action codes of channels 0, 1, 2 and 3 sit in bits 5:4, 7:6, 9:8 and 11:10. Every level and every action code resets to 0.
- R10: A write to the control/status word loads bits 3:0 directly into the output levels. If a channel fires in the same cycle with a nonzero code, its action wins over the written bit, using the action code and level held before the write. If the code is 00, the written bit is kept.
- R11: Bits 31:12 of the control/status word read as zero, and writing them has no effect.
- R12: Addresses 0 to 3 select the compare values of channels 0 to 3. A compare value holds bits 15:0, and bits 31:16 read as zero. Address 4 is the control/status word. Address 5 reads the counter, and writes to it are ignored. Read data appears on `regRdData` one cycle after `regRdEn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cntEn | input | 1 | Counter advance enable |
| cntClr | input | 1 | Hold counter at zero |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdEn | input | 1 | Register read strobe |
| regRdData | output | 32 | Registered read data |
| matchOut | output | 4 | Channel output levels |

## Verification
If a channel's edge detector is wrong, an output inverts once per stalled cycle instead of once. The fault shows on `matchOut` one edge after the counter stalls on the compare value. If the counter step or the wrap is wrong, the next action lands late or never, and with a wrap fault this shows only after a full 65536-cycle lap. A wrong action decode or a wrong write priority shows in the very next cycle, on `matchOut` or in the control/status readback one cycle later.

// File: rtl/tmr_match_pkg.sv
package tmr_match_pkg;

  localparam int unsigned NUM_CH   = 4;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned ACT_W    = 2;
  localparam int unsigned ADDR_CS  = 4;
  localparam int unsigned ADDR_CNT = 5;

  typedef enum logic [ACT_W-1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } matchAct_e;

  // strobes from the register decode to the datapath
  typedef struct packed {
    logic [NUM_CH-1:0] mrWr;
    logic              csWr;
    logic              rdStb;
    logic [ADDR_W-1:0] rdSel;
  } ctrlStb_t;

endpackage

// File: rtl/tmr_match_ctrl.sv
module tmr_match_ctrl
  import tmr_match_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output ctrlStb_t          stb
);

  logic [NUM_CH-1:0] mrHit;

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_dec
    assign mrHit[gi] = (regAddr == ADDR_W'(gi));
  end

  always_comb begin
    stb.mrWr  = regWrEn ? mrHit : '0;
    stb.csWr  = regWrEn && (regAddr == ADDR_W'(ADDR_CS));
    stb.rdStb = regRdEn;
    stb.rdSel = regAddr;
  end

  // R12: a write reaches at most one register
  p_one_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.mrWr, stb.csWr}));

  // R12: writes to the counter address touch no register
  p_cnt_addr_ro_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == ADDR_W'(ADDR_CNT)) |-> (stb.mrWr == '0 && !stb.csWr));

endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
  import tmr_match_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] mrVal,
  input  matchAct_e        act,
  input  logic             wrEn,
  input  logic             wrBit,
  output logic             levelQ
);

  logic eqNow;
  logic eqQ;
  logic hit;
  logic levelNxt;

  assign eqNow = (cnt == mrVal);
  assign hit   = eqNow && !eqQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eqQ <= 1'b0;
    else        eqQ <= eqNow;
  end

  always_comb begin
    levelNxt = levelQ;
    if (wrEn) levelNxt = wrBit;
    if (hit) begin
      unique case (act)
        ACT_LOW:  levelNxt = 1'b0;
        ACT_HIGH: levelNxt = 1'b1;
        ACT_FLIP: levelNxt = !levelQ;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) levelQ <= 1'b0;
    else        levelQ <= levelNxt;
  end

  p_fire_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn && !(hit && act != ACT_KEEP)) |=> $stable(levelQ));

  p_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == ACT_LOW) |=> !levelQ);

  p_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == ACT_HIGH) |=> levelQ);

  p_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == ACT_FLIP) |=> (levelQ != $past(levelQ)));

  p_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !(hit && act != ACT_KEEP)) |=> (levelQ == $past(wrBit)));

endmodule

// File: rtl/tmr_match_dp.sv
module tmr_match_dp
  import tmr_match_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cntEn,
  input  logic              cntClr,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] levels
);

  localparam int unsigned CS_W = NUM_CH * (1 + ACT_W);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  mrQ  [NUM_CH];
  matchAct_e         actQ [NUM_CH];
  logic [CS_W-1:0]   csWord;
  logic [DATA_W-1:0] rdNext;
  logic              unusedWrHi;

  assign unusedWrHi = ^wrData[DATA_W-1:CNT_W];

  // free-running counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cntClr) cnt <= '0;
    else if (cntEn)  cnt <= cnt + 1'b1;
  end

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mrQ[gi]  <= '0;
        actQ[gi] <= ACT_KEEP;
      end else begin
        if (stb.mrWr[gi]) mrQ[gi] <= wrData[CNT_W-1:0];
        if (stb.csWr)
          actQ[gi] <= matchAct_e'(wrData[NUM_CH + ACT_W*gi +: ACT_W]);
      end
    end

    tmr_match_chan #(.CNT_W(CNT_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt    (cnt),
      .mrVal  (mrQ[gi]),
      .act    (actQ[gi]),
      .wrEn   (stb.csWr),
      .wrBit  (wrData[gi]),
      .levelQ (levels[gi])
    );

    assign csWord[NUM_CH + ACT_W*gi +: ACT_W] = actQ[gi];
  end

  assign csWord[NUM_CH-1:0] = levels;

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (stb.rdSel == ADDR_W'(i)) rdNext = DATA_W'(mrQ[i]);
    if (stb.rdSel == ADDR_W'(ADDR_CS))  rdNext = DATA_W'(csWord);
    if (stb.rdSel == ADDR_W'(ADDR_CNT)) rdNext = DATA_W'(cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdData <= '0;
    else if (stb.rdStb) rdData <= rdNext;
  end

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cntEn && !cntClr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cntEn && !cntClr) |=> $stable(cnt));

  p_count_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cntClr |=> (cnt == '0));

  p_cs_hi_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdStb && stb.rdSel == ADDR_W'(ADDR_CS)) |=> (rdData[DATA_W-1:CS_W] == '0));

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.rdStb |=> $stable(rdData));

endmodule

// File: rtl/tmr_match_top.sv
module tmr_match_top
  import tmr_match_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cntEn,
  input  logic              cntClr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  output logic [DATA_W-1:0] regRdData,
  output logic [NUM_CH-1:0] matchOut
);

  ctrlStb_t stb;

  tmr_match_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .stb     (stb)
  );

  tmr_match_dp #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .cntEn  (cntEn),
    .cntClr (cntClr),
    .stb    (stb),
    .wrData (regWrData),
    .rdData (regRdData),
    .levels (matchOut)
  );

endmodule

// File: tb/tmr_match_top_tb.sv
`timescale 1ns/1ps
module tmr_match_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cntEn = 1'b1;
  logic        cntClr = 1'b1;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic [3:0]  matchOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  tmr_match_top u_dut (
    .clk(clk), .rst_n(rst_n), .cntEn(cntEn), .cntClr(cntClr),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .matchOut(matchOut)
  );

  // {channel[1:0], action[1:0], start level, expected level}
  localparam logic [5:0] VEC [16] = '{
    6'b00_00_1_1, 6'b00_01_1_0, 6'b00_10_0_1, 6'b00_11_0_1,
    6'b01_00_0_0, 6'b01_01_0_0, 6'b01_10_1_1, 6'b01_11_1_0,
    6'b10_11_1_0, 6'b10_10_0_1, 6'b10_01_1_0, 6'b10_00_1_1,
    6'b11_01_1_0, 6'b11_11_0_1, 6'b11_00_0_0, 6'b11_10_0_1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 180000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R9)
    check("R9 outputs after reset", 32'(matchOut), 32'h0);
    rdReg(3'd4, rd); check("R9 control word after reset", rd, 32'h0);
    rdReg(3'd0, rd); check("R12 compare 0 after reset", rd, 32'h0);
    rdReg(3'd5, rd); check("R2 counter held by clear", rd, 32'h0);

    // R11: upper bits of the control word
    wrReg(3'd4, 32'hFFFF_FFFF);
    rdReg(3'd4, rd); check("R11 upper bits read zero", rd, 32'h0000_0FFF);
    check("R10 levels loaded by write", 32'(matchOut), 32'hF);
    wrReg(3'd4, 32'hFFFF_F000);
    rdReg(3'd4, rd); check("R11 upper write ignored", rd, 32'h0);

    // R12: compare width
    wrReg(3'd3, 32'hABCD_1234);
    rdReg(3'd3, rd); check("R12 compare 3 is 16 bits", rd, 32'h0000_1234);

    // R1: counter step and hold
    cntEn = 1'b0; cntClr = 1'b0;
    rdReg(3'd5, rd); check("R1 held counter", rd, 32'h0);
    cntEn = 1'b1;
    repeat (7) @(posedge clk);
    @(negedge clk); cntEn = 1'b0;
    rdReg(3'd5, rd); check("R1 seven steps", rd, 32'd7);
    wrReg(3'd5, 32'h1234);
    rdReg(3'd5, rd); check("R12 counter write ignored", rd, 32'd7);
    // R2: clear wins over enable
    cntEn = 1'b1; cntClr = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rdReg(3'd5, rd); check("R2 clear over enable", rd, 32'h0);

    // table of action codes on every channel
    for (int i = 0; i < 16; i++) begin
      logic [1:0] ch;
      logic [1:0] code;
      logic       init;
      logic       exp;
      logic [15:0] mv;
      string tag;
      ch = VEC[i][5:4]; code = VEC[i][3:2]; init = VEC[i][1]; exp = VEC[i][0];
      mv = 16'(8 + i);
      case (code)
        2'b00:   tag = "R5 keep";
        2'b01:   tag = "R6 low";
        2'b10:   tag = "R7 high";
        default: tag = "R8 flip";
      endcase
      wrReg(3'(ch), 32'(mv));
      wrReg(3'd4, (32'(code) << (4 + 2*ch)) | (32'(init) << ch));
      check("R10 level written", 32'(matchOut[ch]), 32'(init));
      cntClr = 1'b0;
      repeat (int'(mv)) @(posedge clk);
      @(negedge clk);
      check("R4 no early action", 32'(matchOut[ch]), 32'(init));
      @(posedge clk); @(negedge clk);
      check(tag, 32'(matchOut[ch]), 32'(exp));
      cntClr = 1'b1;
      @(posedge clk); @(negedge clk);
    end

    // R3/R4: stall on the compare value
    wrReg(3'd0, 32'd20);
    wrReg(3'd4, 32'h30);
    cntClr = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk); cntEn = 1'b0;
    check("R4 before edge", 32'(matchOut[0]), 32'h0);
    @(posedge clk); @(negedge clk);
    check("R4 after edge", 32'(matchOut[0]), 32'h1);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R3 fires once while stalled", 32'(matchOut[0]), 32'h1);
    cntEn = 1'b1; cntClr = 1'b1;
    @(posedge clk); @(negedge clk);

    // R10: write collides with a match
    wrReg(3'd1, 32'd30);
    wrReg(3'd2, 32'd30);
    wrReg(3'd3, 32'd30);
    wrReg(3'd4, 32'h480);
    cntClr = 1'b0;
    repeat (30) @(posedge clk);
    @(negedge clk);
    wrReg(3'd4, 32'h48C);
    check("R10 match wins, keep uses write", 32'(matchOut), 32'h6);
    rdReg(3'd4, rd); check("R9 control word after collision", rd, 32'h486);
    cntClr = 1'b1;
    @(posedge clk); @(negedge clk);

    // R8: toggles on consecutive wraps, R1 wrap
    wrReg(3'd0, 32'd5);
    wrReg(3'd4, 32'h30);
    cntClr = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R8 before first flip", 32'(matchOut[0]), 32'h0);
    @(posedge clk); @(negedge clk);
    check("R8 first flip", 32'(matchOut[0]), 32'h1);
    repeat (65529) @(posedge clk);
    @(negedge clk); cntEn = 1'b0;
    rdReg(3'd5, rd); check("R1 counter at top", rd, 32'hFFFF);
    cntEn = 1'b1;
    @(posedge clk); @(negedge clk); cntEn = 1'b0;
    rdReg(3'd5, rd); check("R1 wrap to zero", rd, 32'h0);
    cntEn = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R8 level held over wrap", 32'(matchOut[0]), 32'h1);
    @(posedge clk); @(negedge clk);
    check("R8 second flip", 32'(matchOut[0]), 32'h0);
    repeat (65535) @(posedge clk);
    @(negedge clk);
    check("R8 level held second lap", 32'(matchOut[0]), 32'h0);
    @(posedge clk); @(negedge clk);
    check("R8 third flip", 32'(matchOut[0]), 32'h1);

    finishRun();
  end

endmodule